// File: doc/BRIEF.md
# Table-driven CRC-16 engine

This block computes a 16-bit cyclic redundancy check over a stream of bytes, one byte per table lookup. After reset an internal sequencer builds a 256-entry remainder table, one entry per byte value, by running a bit-serial shift-and-XOR divider eight steps per entry. The table is built once. All later messages read from the same table without rebuilding it.

A byte enters through a valid/ready handshake. A byte moves when `in_valid_i` and `in_ready_o` are both high at a rising edge. `in_ready_o` stays low while the table is being built, and for the two cycles after each accepted byte. A sender that holds `in_valid_i` high must keep its data, last flag, start strobe and seed stable until the byte is taken. Each accepted byte takes three cycles: the table index is formed, then the table RAM is read, then the running CRC is updated. The start strobe `sof_i` loads a new seed. The seed is either a full 16-bit word or one byte copied into both halves. The strobe can come alone or together with the first byte of a message. `done_o` marks the update that absorbs the byte flagged as last.

The arithmetic uses generator polynomial 0x1021, processed MSB first, with no reflection and no final XOR.

Top module: `crc16_lut_engine`

## Requirements
- R1: After `rst_n` is released, `crc_o` is 0x0000, `done_o` is 0 and `in_ready_o` is 0. `in_ready_o` first reads 1 after the 2048th rising edge with `rst_n` high (256 entries × 8 shift steps).
- R2: For an accepted byte d, the new `crc_o` is T[d XOR old[15:8]] XOR (old[7:0] << 8). T[j] is the value reached from j << 8 after eight MSB-first shifts, with 0x1021 XORed in whenever a 1 is shifted out. Bytes "123456789" from seed 0xFFFF give 0x29B1.
- R3: A `sof_i` taken while `in_ready_o` is 1 selects the seed. The seed is {`seed_byte_i`,`seed_byte_i`} when `seed_byte_en_i` is 1, and `seed_word_i` otherwise. With no byte in the same cycle, `crc_o` equals the seed one cycle later. With a byte in the same cycle, that byte is folded into the seed instead of into the old CRC.
- R4: After a byte is accepted at edge E, `in_ready_o` is 0 and `crc_o` is unchanged after E and after E+1. The updated `crc_o` and `in_ready_o` = 1 appear after E+2, so the block takes one byte every three cycles.
- R5: `done_o` is 1 for exactly one cycle, in the cycle in which the CRC of a byte accepted with `in_last_i` = 1 first appears on `crc_o`. It is 0 after bytes accepted with `in_last_i` = 0.
- R6: While `in_ready_o` is 0, whether during the table build or during a byte, `in_valid_i`, `in_data_i`, `in_last_i`, `sof_i` and the seed inputs have no effect on `crc_o` or `done_o`.
- R7: The table is never rebuilt. Once `in_ready_o` has first risen, it is never 0 for more than two cycles in a row.
- R8: A one-byte message accepted in the very first cycle with `in_ready_o` = 1 after reset gives the correct CRC and a `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; starts the table build |
| sof_i | input | 1 | Start-of-message strobe; loads the selected seed |
| seed_word_i | input | 16 | Full 16-bit seed |
| seed_byte_i | input | 8 | Byte seed, copied into both halves |
| seed_byte_en_i | input | 1 | 1 selects the byte seed, 0 selects the word seed |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Engine can take a byte (table built and idle) |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Marks the final byte of a message |
| crc_o | output | 16 | Running CRC |
| done_o | output | 1 | One-cycle pulse when the last byte's CRC is on `crc_o` |

## Verification
Each result is due a fixed number of cycles after its stimulus. `in_ready_o` rises exactly 2048 edges after reset. A seed loaded by a lone strobe appears one edge later. A byte's CRC and its `done_o` appear two edges after the accepting edge, and `done_o` is low again one edge after that. The bench drives every input on a falling edge and samples on the falling edge at exactly those distances. It also confirms that `crc_o` has not moved at the intermediate samples. During the busy cycles it deliberately drives other bytes, strobes and seeds, and it checks every CRC against a bitwise MSB-first divider written in the bench.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  parameter int unsigned CRC_W_DEF  = 16;
  parameter int unsigned DATA_W_DEF = 8;
  parameter logic [CRC_W_DEF-1:0] POLY_DEF = 16'h1021;

  // engine phases: one per cycle of a byte
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_UPDATE = 2'd2
  } eng_st_e;
endpackage

// File: rtl/crc16_tbl_fill.sv
// Bit-serial divider that generates the remainder table after reset.
module crc16_tbl_fill #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_addr_o,
  output logic [CRC_W-1:0]  wr_data_o,
  output logic              built_o
);
  localparam int unsigned SW = $clog2(DATA_W);
  localparam int unsigned PAD_W = CRC_W - DATA_W;

  logic [DATA_W-1:0] entry_q, entry_nx;
  logic [SW-1:0]     step_q;
  logic [CRC_W-1:0]  work_q, shifted;
  logic              built_q, last_step;

  assign shifted   = work_q[CRC_W-1] ? ({work_q[CRC_W-2:0], 1'b0} ^ POLY)
                                     :  {work_q[CRC_W-2:0], 1'b0};
  assign last_step = (step_q == SW'(DATA_W - 1));
  assign entry_nx  = entry_q + DATA_W'(1);

  assign wr_en_o   = !built_q && last_step;
  assign wr_addr_o = entry_q;
  assign wr_data_o = shifted;
  assign built_o   = built_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q <= '0;
      step_q  <= '0;
      work_q  <= '0;
      built_q <= 1'b0;
    end else if (!built_q) begin
      if (last_step) begin
        step_q  <= '0;
        entry_q <= entry_nx;
        work_q  <= {entry_nx, {PAD_W{1'b0}}};
        if (&entry_q) built_q <= 1'b1;
      end else begin
        step_q <= step_q + SW'(1);
        work_q <= shifted;
      end
    end
  end
endmodule

// File: rtl/crc16_tbl_ram.sv
// Simple dual-port table store, one-cycle registered read.
module crc16_tbl_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/crc16_lut_engine.sv
module crc16_lut_engine
  import crc16_pkg::*;
#(
  parameter int unsigned CRC_W  = CRC_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter logic [CRC_W-1:0] POLY = POLY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic [CRC_W-1:0]  seed_word_i,
  input  logic [DATA_W-1:0] seed_byte_i,
  input  logic              seed_byte_en_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);
  localparam int unsigned LO_W = CRC_W - DATA_W;
  localparam int unsigned REP  = CRC_W / DATA_W;

  logic              tbl_we, tbl_built;
  logic [DATA_W-1:0] tbl_waddr;
  logic [CRC_W-1:0]  tbl_wdata, tbl_rdata;

  eng_st_e           st_q;
  logic [DATA_W-1:0] idx_q;
  logic [LO_W-1:0]   lo_q;
  logic              last_q, done_q;
  logic [CRC_W-1:0]  crc_q, seed_val, base;
  logic              take, sof_go;

  crc16_tbl_fill #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_o   (tbl_we),
    .wr_addr_o (tbl_waddr),
    .wr_data_o (tbl_wdata),
    .built_o   (tbl_built)
  );

  crc16_tbl_ram #(.AW(DATA_W), .DW(CRC_W)) u_ram (
    .clk     (clk),
    .we_i    (tbl_we),
    .waddr_i (tbl_waddr),
    .wdata_i (tbl_wdata),
    .raddr_i (idx_q),
    .rdata_o (tbl_rdata)
  );

  assign in_ready_o = tbl_built && (st_q == ST_IDLE);
  assign take       = in_valid_i && in_ready_o;
  assign sof_go     = sof_i && in_ready_o;
  assign seed_val   = seed_byte_en_i ? {REP{seed_byte_i}} : seed_word_i;
  assign base       = sof_go ? seed_val : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      lo_q   <= '0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      crc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (take) begin
            // cycle 1: form the table index
            idx_q  <= in_data_i ^ base[CRC_W-1 -: DATA_W];
            lo_q   <= base[LO_W-1:0];
            last_q <= in_last_i;
            st_q   <= ST_READ;
          end else if (sof_go) begin
            crc_q <= seed_val;
          end
        end
        // cycle 2: registered table read
        ST_READ: st_q <= ST_UPDATE;
        // cycle 3: combine entry with the shifted low part
        ST_UPDATE: begin
          crc_q  <= tbl_rdata ^ {lo_q, {DATA_W{1'b0}}};
          done_q <= last_q;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign crc_o  = crc_q;
  assign done_o = done_q;
endmodule

// File: rtl/crc16_lut_engine_chk.sv
module crc16_lut_engine_chk #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sof_i,
  input logic [CRC_W-1:0]  seed_word_i,
  input logic [DATA_W-1:0] seed_byte_i,
  input logic              seed_byte_en_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [CRC_W-1:0]  crc_o,
  input logic              done_o
);
  localparam int unsigned FILL_CYC = (1 << DATA_W) * DATA_W;
  localparam int unsigned CW = $clog2(FILL_CYC) + 1;
  localparam int unsigned REP = CRC_W / DATA_W;

  logic [CW-1:0] cyc_q;
  logic [1:0]    low_q;
  logic          opened;

  assign opened = (cyc_q == CW'(FILL_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      low_q <= '0;
    end else begin
      if (!opened) cyc_q <= cyc_q + CW'(1);
      if (in_ready_o || !opened) low_q <= '0;
      else if (low_q != 2'd3)    low_q <= low_q + 2'd1;
    end
  end

  p_fill_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !opened |-> !in_ready_o);

  p_no_rebuild_r7: assert property (@(posedge clk) disable iff (!rst_n)
    opened |-> (low_q <= 2'd2));

  p_seed_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && in_ready_o && !in_valid_i && !seed_byte_en_i)
      |=> (crc_o == $past(seed_word_i)));

  p_seed_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && in_ready_o && !in_valid_i && seed_byte_en_i)
      |=> (crc_o == {REP{$past(seed_byte_i)}}));

  p_busy_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  p_crc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> $stable(crc_o));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> in_ready_o);
endmodule

bind crc16_lut_engine crc16_lut_engine_chk #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sof_i          (sof_i),
  .seed_word_i    (seed_word_i),
  .seed_byte_i    (seed_byte_i),
  .seed_byte_en_i (seed_byte_en_i),
  .in_valid_i     (in_valid_i),
  .in_ready_o     (in_ready_o),
  .crc_o          (crc_o),
  .done_o         (done_o)
);

// File: tb/sim_crc16_lut_engine.sv
`timescale 1ns/1ps
module sim_crc16_lut_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof_i = 1'b0;
  logic [15:0] seed_word_i = '0;
  logic [7:0]  seed_byte_i = '0;
  logic        seed_byte_en_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_data_i = '0;
  logic        in_last_i = 1'b0;
  logic [15:0] crc_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  logic [15:0] exp_crc = '0;

  always #5 clk = ~clk;

  crc16_lut_engine u0 (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .seed_word_i(seed_word_i),
    .seed_byte_i(seed_byte_i), .seed_byte_en_i(seed_byte_en_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_last_i(in_last_i), .crc_o(crc_o), .done_o(done_o)
  );

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wait_ready();
    while (!in_ready_o) @(negedge clk);
  endtask

  task automatic sof_only(input bit use_b, input logic [15:0] sw, input logic [7:0] sb);
    wait_ready();
    sof_i = 1'b1; seed_byte_en_i = use_b; seed_word_i = sw; seed_byte_i = sb;
    @(negedge clk);
    sof_i = 1'b0;
    exp_crc = use_b ? {sb, sb} : sw;
    chk(crc_o == exp_crc, "R3 lone seed load", crc_o, exp_crc);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit last, input bit sof,
                           input bit use_b, input logic [15:0] sw, input logic [7:0] sb);
    logic [15:0] base, pre;
    wait_ready();
    pre  = crc_o;
    base = sof ? (use_b ? {sb, sb} : sw) : exp_crc;
    exp_crc = ref_byte(base, d);
    in_valid_i = 1'b1; in_data_i = d; in_last_i = last; sof_i = sof;
    seed_byte_en_i = use_b; seed_word_i = sw; seed_byte_i = sb;
    @(negedge clk);
    chk(!in_ready_o, "R4 busy after accept", in_ready_o, 0);
    chk(crc_o == pre, "R4 crc held edge 1", crc_o, pre);
    // R6: competing traffic while busy must be ignored
    in_valid_i = 1'b1; in_data_i = ~d; in_last_i = 1'b1; sof_i = 1'b1;
    seed_word_i = ~sw; seed_byte_i = ~sb; seed_byte_en_i = ~use_b;
    @(negedge clk);
    in_valid_i = 1'b0; in_last_i = 1'b0; sof_i = 1'b0;
    chk(!in_ready_o, "R4 busy edge 2", in_ready_o, 0);
    chk(crc_o == pre, "R4 crc held edge 2", crc_o, pre);
    chk(done_o == 1'b0, "R6 no done while busy", done_o, 0);
    @(negedge clk);
    chk(crc_o == exp_crc, "R2 byte update", crc_o, exp_crc);
    chk(in_ready_o, "R7 ready after two busy cycles", in_ready_o, 1);
    chk(done_o == last, "R5 done with last", done_o, last);
    if (last) begin
      @(negedge clk);
      chk(done_o == 1'b0, "R5 done single cycle", done_o, 0);
      chk(crc_o == exp_crc, "R5 crc stable after done", crc_o, exp_crc);
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [7:0] vec [9];
    void'($urandom(32'h5EED_C0DE));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(crc_o == 16'h0000, "R1 reset crc", crc_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    chk(in_ready_o == 1'b0, "R1 reset ready", in_ready_o, 0);

    // R6: traffic during table build is ignored
    in_valid_i = 1'b1; sof_i = 1'b1; seed_word_i = 16'hBEEF; in_data_i = 8'hAA; in_last_i = 1'b1;
    n = 0;
    while (!in_ready_o && n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 100) begin
        in_valid_i = 1'b0; sof_i = 1'b0; in_last_i = 1'b0;
      end
      if (done_o) chk(1'b0, "R6 done during fill", done_o, 0);
    end
    chk(n == 2048, "R1 fill length", n, 2048);
    chk(crc_o == 16'h0000, "R6 fill ignores seed", crc_o, 0);

    // R8: single byte right away
    send_byte(8'h5A, 1'b1, 1'b1, 1'b0, 16'h1D0F, 8'h00);
    chk(crc_o == ref_byte(16'h1D0F, 8'h5A), "R8 first message", crc_o, ref_byte(16'h1D0F, 8'h5A));

    // R2: known check value
    for (int i = 0; i < 9; i++) vec[i] = 8'h31 + 8'(i);
    for (int i = 0; i < 9; i++)
      send_byte(vec[i], i == 8, i == 0, 1'b0, 16'hFFFF, 8'h00);
    chk(crc_o == 16'h29B1, "R2 check string", crc_o, 16'h29B1);

    // R3: byte seed with first byte, lone strobes
    send_byte(8'h00, 1'b1, 1'b1, 1'b1, 16'h0000, 8'hC3);
    sof_only(1'b0, 16'hA55A, 8'h11);
    sof_only(1'b1, 16'h0000, 8'h7E);
    send_byte(8'hFF, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h00);

    // random messages
    for (int m = 0; m < 40; m++) begin
      int len, mode;
      logic [15:0] sw;
      logic [7:0] sb;
      len  = 1 + int'($urandom_range(0, 11));
      mode = int'($urandom_range(0, 2));
      sw   = 16'($urandom);
      sb   = 8'($urandom);
      if (mode == 2) sof_only($urandom_range(0, 1) == 1, sw, sb);
      for (int b = 0; b < len; b++) begin
        send_byte(8'($urandom), b == len - 1, (mode != 2) && (b == 0), mode == 1, sw, sb);
        repeat (int'($urandom_range(0, 2))) @(negedge clk);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule